// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a core that runs in one of four privilege levels. Software in every level addresses thirty-two architectural registers through a 5-bit index. The storage behind them is split into three parts. The lowest eight registers are one set of storage seen by all levels, so a caller and a handler can pass arguments through them. Above that, the user level owns a private bank. The three system levels share a second bank. Because of this split, a trap from user code into any system level does not need to save or restore the user's upper registers.

The core presents the current privilege level on a 2-bit input. Two read ports return data combinationally from an index. One write port commits on the rising clock edge. Each port turns its architectural index into a physical entry using the level that is present in the same cycle.

Top module: `mode_banked_regfile`

## Requirements
- R1: After reset every register reads as zero in all four levels.
- R2: A write to index 0..7 from any level is visible at the same index in every level.
- R3: A write to index 8..31 in level 0 (user) is not visible at that index from levels 1, 2 or 3.
- R4: Levels 1, 2 and 3 address one common bank for index 8..31: a write in any of them is visible from the other two.
- R5: A write to index 8..31 from level 1, 2 or 3 leaves the user-level contents of that index unchanged.
- R6: Read data follows the read index and the level within the same cycle, with no clock edge needed.
- R7: When a read and a write target the same register in one cycle, the read returns the old value until the clock edge and the new value afterwards.
- R8: The two read ports are independent: each returns the register named by its own index, and both agree when the indices are equal.
- R9: With the write enable low, the clock edge changes no register, whatever the write index and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write commits on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all storage |
| mode_i | input | 2 | Current privilege level: 0 user, 1 to 3 system |
| rd_a_idx_i | input | 5 | Architectural index for read port A |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_idx_i | input | 5 | Architectural index for read port B |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Architectural index for the write |
| wr_data_i | input | DATA_W | Write data |

## Verification
The bench builds the block with DATA_W set to 16 and keeps the register count and the shared-set size at their defaults. With a narrow word, each written value can carry the level and the index that wrote it. Any aliasing between the shared set and the two banks then shows up as a wrong tag on a read. The register space is small enough that the bench writes every index from every level and reads all 32 indices back from all four levels on both ports after each pass, which covers every combination of mapping.

// File: rtl/mbrf_pkg.sv
// Package: shared types for the mode-banked register file.
// Assumes level 0 is the only unprivileged level; every other encoding is a system level.
package mbrf_pkg;

    typedef enum logic [1:0] {
        MODE_USER  = 2'd0,
        MODE_SYS_A = 2'd1,
        MODE_SYS_B = 2'd2,
        MODE_SYS_C = 2'd3
    } priv_mode_e;

endpackage

// File: rtl/mbrf_bank_map.sv
// Module: mbrf_bank_map
// Turns an architectural index and a privilege level into a physical entry number.
// Physical layout: [0, NUM_SHARED) common set, then the user bank, then the system bank.
// Assumes NUM_SHARED < NUM_ARCH and that PHYS_W can hold NUM_SHARED + 2*(NUM_ARCH-NUM_SHARED).
module mbrf_bank_map
    import mbrf_pkg::*;
#(
    parameter int NUM_ARCH   = 32,
    parameter int NUM_SHARED = 8,
    parameter int IDX_W      = $clog2(NUM_ARCH),
    parameter int PHYS_W     = $clog2(NUM_SHARED + 2 * (NUM_ARCH - NUM_SHARED))
) (
    input  logic [IDX_W-1:0]  arch_idx_i,
    input  priv_mode_e        mode_i,
    output logic [PHYS_W-1:0] phys_idx_o
);

    localparam int BANK_SPAN = NUM_ARCH - NUM_SHARED;

    logic is_common;
    logic is_user;

    // Classify the access: common low set, or a banked register seen by user or system.
    always_comb begin
        is_common = (arch_idx_i < IDX_W'(NUM_SHARED));
        is_user   = (mode_i == MODE_USER);
    end

    // Offset system-level banked accesses past the user bank.
    always_comb begin
        if (is_common || is_user) begin
            phys_idx_o = PHYS_W'(arch_idx_i);
        end else begin
            phys_idx_o = PHYS_W'(arch_idx_i) + PHYS_W'(BANK_SPAN);
        end
    end

endmodule

// File: rtl/mbrf_storage.sv
// Module: mbrf_storage
// Flop-based physical storage with NUM_RD combinational read ports and one write port.
// Assumes physical indices are already range-checked by the mapping logic.
// A same-cycle read of the entry being written returns the value held before the edge.
module mbrf_storage #(
    parameter int DATA_W   = 64,
    parameter int NUM_PHYS = 56,
    parameter int NUM_RD   = 2,
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [PHYS_W-1:0]              wr_phys_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    input  logic [NUM_RD-1:0][PHYS_W-1:0]  rd_phys_i,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o
);

    logic [DATA_W-1:0] entry_q [NUM_PHYS];

    // Clear every entry on reset; otherwise update the single addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_PHYS; e++) begin
                entry_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < NUM_PHYS; e++) begin
                if (wr_en_i && (wr_phys_i == PHYS_W'(e))) begin
                    entry_q[e] <= wr_data_i;
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        // Combinational read mux for port p.
        always_comb begin
            rd_data_o[p] = entry_q[rd_phys_i[p]];
        end
    end

endmodule

// File: rtl/mode_banked_regfile.sv
// Module: mode_banked_regfile
// Register file in which the low registers are common to all privilege levels, the
// user level owns a private upper bank, and the system levels share a second upper bank.
// Assumes a single current level that applies to both reads and the write in a cycle.
module mode_banked_regfile
    import mbrf_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int NUM_ARCH   = 32,
    parameter int NUM_SHARED = 8,
    parameter int IDX_W      = $clog2(NUM_ARCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    localparam int NUM_RD   = 2;
    localparam int NUM_PHYS = NUM_SHARED + 2 * (NUM_ARCH - NUM_SHARED);
    localparam int PHYS_W   = $clog2(NUM_PHYS);

    priv_mode_e                          cur_mode;
    logic [NUM_RD-1:0][IDX_W-1:0]        rd_arch;
    logic [NUM_RD-1:0][PHYS_W-1:0]       rd_phys;
    logic [NUM_RD-1:0][DATA_W-1:0]       rd_data;
    logic [PHYS_W-1:0]                   wr_phys;

    // Collect the port-level inputs into the internal per-port arrays.
    always_comb begin
        cur_mode   = priv_mode_e'(mode_i);
        rd_arch[0] = rd_a_idx_i;
        rd_arch[1] = rd_b_idx_i;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd_map
        mbrf_bank_map #(
            .NUM_ARCH   (NUM_ARCH),
            .NUM_SHARED (NUM_SHARED),
            .IDX_W      (IDX_W),
            .PHYS_W     (PHYS_W)
        ) u_map (
            .arch_idx_i (rd_arch[p]),
            .mode_i     (cur_mode),
            .phys_idx_o (rd_phys[p])
        );
    end

    mbrf_bank_map #(
        .NUM_ARCH   (NUM_ARCH),
        .NUM_SHARED (NUM_SHARED),
        .IDX_W      (IDX_W),
        .PHYS_W     (PHYS_W)
    ) u_wr_map (
        .arch_idx_i (wr_idx_i),
        .mode_i     (cur_mode),
        .phys_idx_o (wr_phys)
    );

    mbrf_storage #(
        .DATA_W   (DATA_W),
        .NUM_PHYS (NUM_PHYS),
        .NUM_RD   (NUM_RD),
        .PHYS_W   (PHYS_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_phys_i (wr_phys),
        .wr_data_i (wr_data_i),
        .rd_phys_i (rd_phys),
        .rd_data_o (rd_data)
    );

    // Drive the read ports from the storage outputs.
    always_comb begin
        rd_a_data_o = rd_data[0];
        rd_b_data_o = rd_data[1];
    end

endmodule

// File: rtl/mode_banked_regfile_chk.sv
// Module: mode_banked_regfile_chk
// Port-level checker for mode_banked_regfile, attached by bind below.
// Assumes inputs are driven to known values from time zero.
module mode_banked_regfile_chk #(
    parameter int DATA_W     = 64,
    parameter int NUM_SHARED = 8,
    parameter int IDX_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [IDX_W-1:0]  rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [IDX_W-1:0]  rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_a_data_o == '0 && rd_b_data_o == '0)); // R1

    AST_COMMON_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && $past(wr_idx_i) < IDX_W'(NUM_SHARED)
         && rd_a_idx_i == $past(wr_idx_i)) |-> rd_a_data_o == $past(wr_data_i)); // R2

    AST_BANK_SAME_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && $past(wr_idx_i) >= IDX_W'(NUM_SHARED)
         && rd_a_idx_i == $past(wr_idx_i) && ((mode_i == 2'd0) == ($past(mode_i) == 2'd0)))
        |-> rd_a_data_o == $past(wr_data_i)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en_i) && $stable(mode_i) && $stable(rd_a_idx_i))
        |-> $stable(rd_a_data_o)); // R9

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o)); // R8

endmodule

bind mode_banked_regfile mode_banked_regfile_chk #(
    .DATA_W     (DATA_W),
    .NUM_SHARED (NUM_SHARED),
    .IDX_W      (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .rd_a_idx_i  (rd_a_idx_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_idx_i  (rd_b_idx_i),
    .rd_b_data_o (rd_b_data_o),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i)
);

// File: tb/mode_banked_regfile_tb.sv
// Bench: sweeps every index from every level with tagged values, then reads back all
// 32 indices in all four levels on both ports, comparing against a three-array model.
module mode_banked_regfile_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [4:0]    ra = '0, rb = '0, wi = '0;
    logic [DW-1:0] da, db, wd = '0;
    logic          we = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] m_com [8];
    logic [DW-1:0] m_usr [24];
    logic [DW-1:0] m_sys [24];

    always #2.5 clk = ~clk;

    mode_banked_regfile #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .rd_a_idx_i(ra), .rd_a_data_o(da),
        .rd_b_idx_i(rb), .rd_b_data_o(db),
        .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd)
    );

    function automatic logic [DW-1:0] model_rd(input logic [1:0] m, input int idx);
        if (idx < 8) return m_com[idx];
        if (m == 2'd0) return m_usr[idx-8];
        return m_sys[idx-8];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (mode %0d ra %0d rb %0d)", req, act, exp, mode, ra, rb);
        end
    endtask

    task automatic do_write(input logic [1:0] m, input int idx, input logic [DW-1:0] v);
        @(negedge clk);
        mode = m; wi = 5'(idx); wd = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (idx < 8) m_com[idx] = v;
        else if (m == 2'd0) m_usr[idx-8] = v;
        else m_sys[idx-8] = v;
    endtask

    // Full read-back on both ports; indices change without clocking (R6).
    task automatic read_all(input string req);
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 32; i++) begin
                mode = 2'(m); ra = 5'(i); rb = 5'(31 - i);
                #0.5;
                check(req, da, model_rd(2'(m), i));
                check("R8", db, model_rd(2'(m), 31 - i));
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_com[i] = '0;
        for (int i = 0; i < 24; i++) begin m_usr[i] = '0; m_sys[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1");

        // Each level writes all 32 indices with values tagged by level and index.
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 32; i++) begin
                do_write(2'(m), i, {2'(m), 5'(i), 9'h0A5 ^ 9'(m * 37 + i)});
            end
            // After user pass: R2/R3; after system passes: R4/R5 also hold.
            read_all(m == 0 ? "R2_R3_R6" : "R2_R4_R5");
        end

        // R5: system write to a banked index leaves the user view intact.
        do_write(2'd2, 20, 16'hBEEF);
        @(negedge clk); mode = 2'd0; ra = 5'd20; #0.5;
        check("R5", da, m_usr[12]);
        mode = 2'd3; #0.5;
        check("R4", da, 16'hBEEF);

        // R9: idle write enable with live index and data changes nothing.
        @(negedge clk); mode = 2'd1; wi = 5'd3; wd = 16'h1234; we = 1'b0;
        @(negedge clk); @(negedge clk);
        read_all("R9");

        // R7: read and write of the same register in one cycle.
        @(negedge clk);
        mode = 2'd0; wi = 5'd9; wd = 16'h7777; we = 1'b1; ra = 5'd9;
        #0.5;
        check("R7", da, m_usr[1]);
        @(posedge clk); #0.5;
        we = 1'b0; m_usr[1] = 16'h7777;
        check("R7", da, 16'h7777);
        mode = 2'd1; #0.5;
        check("R3", da, m_sys[1]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule